// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Sign/Zero Condition Register

This block is the execute-stage arithmetic unit of a simple 64-bit sequential processor. Each cycle it combines two operands under a small function code and presents the result combinationally. Next to the adder and logic it keeps a two-bit condition register, holding a sign flag and a zero flag. The register is loaded only at the clock edge that ends a valid arithmetic/logic instruction. Every other instruction leaves it as it was. The block tracks no carry and no overflow.

A separate address mode lets the same adder form memory addresses, such as base plus displacement. In this mode the unit adds the two operands whatever the function code is, and it never alters the flags. The control half decodes the mode inputs into a small set of strobes. The datapath half holds the shared adder, the logic operations and the flag register.

Top module: `alu_cc_unit`

## Requirements
- R1: With address mode low and function code 0, `result` equals `opB + opA` modulo 2^64, in the same cycle.
- R2: With address mode low and function code 1, `result` equals `opB - opA` modulo 2^64. For example, 3 minus 7 gives 0xFFFFFFFFFFFFFFFC.
- R3: With address mode low, function code 2 gives `opB & opA` and function code 3 gives `opB ^ opA`.
- R4: With address mode low, any function code of 4 or above gives a `result` of zero. Such a code leaves both flags unchanged, even when `opValid` is high.
- R5: At a clock edge where `opValid` is high, address mode is low and the code is 0 to 3, `zeroFlag` becomes 1 exactly when `result` was zero.
- R6: At the same kind of edge, `signFlag` becomes 1 exactly when `result` was at least 0x8000000000000000 as an unsigned number (bit 63 set).
- R7: At an edge where `opValid` is low, both flags keep their values. The `result` still follows the function code.
- R8: With `addrMode` high, `result` equals `opA + opB` whatever the function code. The flags keep their values even when `opValid` is high.
- R9: While `rstN` is low, and after it is released until the first flag write, `zeroFlag` is 1 and `signFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the flag register |
| opValid | input | 1 | Current instruction is an arithmetic/logic operation |
| addrMode | input | 1 | Force an add for address generation; flags untouched |
| funcCode | input | FUNC_W (4) | Operation select: 0 add, 1 subtract, 2 AND, 3 XOR |
| opA | input | DATA_W (64) | First operand (subtrahend for subtract) |
| opB | input | DATA_W (64) | Second operand |
| result | output | DATA_W (64) | Combinational operation result |
| signFlag | output | 1 | Registered sign flag |
| zeroFlag | output | 1 | Registered zero flag |

## Verification
The hardest case to see from the ports is an edge that must not touch the flags. Three kinds of edge qualify: an unknown function code, an idle cycle and an address-mode add. If the flags already hold the value the ignored operation would have written, no error shows at all. So before each such edge, the stimulus first puts the flags in the opposite state. It then feeds operands that produce the other pattern, for example a zero result while the zero flag is clear, or a negative result while the sign flag is clear. The bench also uses wrap-around cases, such as all-ones plus one, so that the zero flag comes from a full 64-bit carry-out.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int FN_ADD = 0;
  localparam int FN_SUB = 1;
  localparam int FN_AND = 2;
  localparam int FN_XOR = 3;

  // strobes from control to datapath; at most one select is active
  typedef struct packed {
    logic selAdd;
    logic selSub;
    logic selAnd;
    logic selXor;
    logic ccWrite;
  } aluStrobe_t;

endpackage

// File: rtl/alu_cc_ctrl.sv
module alu_cc_ctrl
  import alu_cc_pkg::*;
#(
  parameter int FUNC_W = 4
) (
  input  logic              opValid,
  input  logic              addrMode,
  input  logic [FUNC_W-1:0] funcCode,
  output aluStrobe_t        strobes
);

  logic knownCode;

  always_comb begin
    strobes   = '0;
    knownCode = 1'b0;
    if (addrMode) begin
      // address generation: plain add, flags left alone
      strobes.selAdd = 1'b1;
    end else begin
      unique case (funcCode)
        FUNC_W'(FN_ADD): begin strobes.selAdd = 1'b1; knownCode = 1'b1; end
        FUNC_W'(FN_SUB): begin strobes.selSub = 1'b1; knownCode = 1'b1; end
        FUNC_W'(FN_AND): begin strobes.selAnd = 1'b1; knownCode = 1'b1; end
        FUNC_W'(FN_XOR): begin strobes.selXor = 1'b1; knownCode = 1'b1; end
        default: ;
      endcase
      strobes.ccWrite = opValid && knownCode;
    end
  end

endmodule

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              signFlag,
  output logic              zeroFlag
);

  localparam int SIGN_BIT = DATA_W - 1;

  logic [DATA_W-1:0] addendA;
  logic [DATA_W-1:0] sumOut;
  logic [DATA_W-1:0] andOut;
  logic [DATA_W-1:0] xorOut;
  logic              nextSign;
  logic              nextZero;

  // one adder serves add, subtract and address generation
  assign addendA = strobes.selSub ? ~opA : opA;
  assign sumOut  = opB + addendA + {{(DATA_W-1){1'b0}}, strobes.selSub};
  assign andOut  = opB & opA;
  assign xorOut  = opB ^ opA;

  always_comb begin
    result = '0;
    if (strobes.selAdd || strobes.selSub) result = sumOut;
    else if (strobes.selAnd)              result = andOut;
    else if (strobes.selXor)              result = xorOut;
  end

  assign nextSign = result[SIGN_BIT];
  assign nextZero = (result == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      signFlag <= 1'b0;
      zeroFlag <= 1'b1;
    end else if (strobes.ccWrite) begin
      signFlag <= nextSign;
      zeroFlag <= nextZero;
    end
  end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              addrMode,
  input  logic [FUNC_W-1:0] funcCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              signFlag,
  output logic              zeroFlag
);

  aluStrobe_t strobes;

  alu_cc_ctrl #(.FUNC_W(FUNC_W)) i_ctrl (
    .opValid (opValid),
    .addrMode(addrMode),
    .funcCode(funcCode),
    .strobes (strobes)
  );

  alu_cc_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .signFlag(signFlag),
    .zeroFlag(zeroFlag)
  );

endmodule

// File: rtl/alu_cc_checker.sv
module alu_cc_checker #(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic              addrMode,
  input logic [FUNC_W-1:0] funcCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic              signFlag,
  input logic              zeroFlag
);

  logic aluWrite;
  assign aluWrite = opValid && !addrMode && (funcCode <= FUNC_W'(3));

  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    aluWrite |=> zeroFlag == ($past(result) == '0)); // R5

  AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    aluWrite |=> signFlag == $past(result[DATA_W-1])); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable({signFlag, zeroFlag})); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    addrMode |=> $stable({signFlag, zeroFlag})); // R8

  AST_ADDR_SUM: assert property (@(posedge clk) disable iff (!rstN)
    addrMode |-> result == opA + opB); // R8

  AST_BADCODE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!addrMode && funcCode > FUNC_W'(3)) |-> result == '0); // R4

  AST_BADCODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!addrMode && funcCode > FUNC_W'(3)) |=> $stable({signFlag, zeroFlag})); // R4

  AST_RESET_FLAGS: assert property (@(posedge clk)
    !rstN |=> (zeroFlag && !signFlag)); // R9

endmodule

bind alu_cc_unit alu_cc_checker #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) i_checker (
  .clk(clk), .rstN(rstN), .opValid(opValid), .addrMode(addrMode),
  .funcCode(funcCode), .opA(opA), .opB(opB), .result(result),
  .signFlag(signFlag), .zeroFlag(zeroFlag)
);

// File: tb/test_alu_cc_unit.sv
`timescale 1ns/1ps
module test_alu_cc_unit;

  localparam int DATA_W = 64;
  localparam int FUNC_W = 4;

  typedef struct {
    string             tag;
    logic [DATA_W-1:0] expResult;
    logic              expSign;
    logic              expZero;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              opValid = 1'b0;
  logic              addrMode = 1'b0;
  logic [FUNC_W-1:0] funcCode = '0;
  logic [DATA_W-1:0] opA = '0;
  logic [DATA_W-1:0] opB = '0;
  logic [DATA_W-1:0] result;
  logic              signFlag;
  logic              zeroFlag;

  int checks = 0;
  int errors = 0;
  expItem_t scoreQ[$];
  logic modelSign = 1'b0;
  logic modelZero = 1'b1;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  alu_cc_unit #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) i_alu_cc_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .addrMode(addrMode),
    .funcCode(funcCode), .opA(opA), .opB(opB), .result(result),
    .signFlag(signFlag), .zeroFlag(zeroFlag)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one operation and pushes its expected outcome
  task automatic drive(input string tag, input logic v, input logic am,
                       input int code, input logic [DATA_W-1:0] a,
                       input logic [DATA_W-1:0] b);
    expItem_t it;
    logic [DATA_W-1:0] r;
    @(negedge clk);
    opValid = v; addrMode = am; funcCode = FUNC_W'(code); opA = a; opB = b;
    if (am) r = a + b;
    else case (code)
      0: r = b + a;
      1: r = b - a;
      2: r = b & a;
      3: r = b ^ a;
      default: r = '0;
    endcase
    if (v && !am && code >= 0 && code <= 3) begin
      modelSign = r[DATA_W-1];
      modelZero = (r == '0);
    end
    it.tag = tag; it.expResult = r; it.expSign = modelSign; it.expZero = modelZero;
    scoreQ.push_back(it);
  endtask

  // monitor: result is combinational, flags are read just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        check({it.tag, " result"}, result, it.expResult);
        check({it.tag, " signFlag"}, {{(DATA_W-1){1'b0}}, signFlag}, {{(DATA_W-1){1'b0}}, it.expSign});
        check({it.tag, " zeroFlag"}, {{(DATA_W-1){1'b0}}, zeroFlag}, {{(DATA_W-1){1'b0}}, it.expZero});
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset zeroFlag", {63'd0, zeroFlag}, 64'd1);
    check("R9 reset signFlag", {63'd0, signFlag}, 64'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R9 after release zeroFlag", {63'd0, zeroFlag}, 64'd1);

    drive("R1 add 7+3",        1, 0, 0, 64'd7, 64'd3);
    drive("R2 sub 3-7",        1, 0, 1, 64'd7, 64'd3);
    drive("R6 sub sign clear", 1, 0, 1, 64'd3, 64'd10);
    drive("R3 and",            1, 0, 2, 64'hF0F0_0000_FFFF_1234, 64'hFF00_FF00_0F0F_FFFF);
    drive("R3 xor",            1, 0, 3, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_00FF);
    drive("R5 xor self zero",  1, 0, 3, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001);
    drive("R1 add wrap zero",  1, 0, 0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    drive("R6 add sign set",   1, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    // flags now SF=1 ZF=0; an ignored zero result must not set ZF
    drive("R7 idle sub zero",  0, 0, 1, 64'd5, 64'd5);
    drive("R4 bad code 5",     1, 0, 5, 64'd9, 64'd9);
    drive("R4 bad code 15",    1, 0, 15, 64'h1234, 64'h8000_0000_0000_0000);
    drive("R8 addr sum zero",  1, 1, 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd16);
    drive("R5 and zero",       1, 0, 2, 64'h00FF, 64'hFF00);
    // flags now SF=0 ZF=1; ignored negative results must not set SF
    drive("R8 addr sum neg",   1, 1, 3, 64'h8000_0000_0000_0000, 64'd4);
    drive("R7 idle add neg",   0, 0, 0, 64'h8000_0000_0000_0000, 64'd0);
    drive("R2 sub wrap",       1, 0, 1, 64'd1, 64'd0);
    @(negedge clk); opValid = 1'b0; addrMode = 1'b0;
    while (scoreQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule